// File: doc/BRIEF.md
# PPS Timebase with Timed Trigger

This block keeps a time scale in hardware from a fast reference clock. A tick counter runs from zero up to an active divisor and then wraps. With a 200 MHz clock and the default divisor of 199 999 999, one wrap is one second. Each wrap advances a 64-bit two's-complement seconds counter and emits a one-clock pulse-per-second strobe. A level trigger rises at a programmed tick offset inside the second and drops when the next second begins. It is meant to start sampling at a precise moment.

A small register port reads and writes the tick and seconds counters at once. It can also stage four things so that they take effect at the next PPS: a new period divisor, a divisor that lasts for one second only, a trigger delay, and a seconds value. Every write to a register is one clock cycle of `wr_en_i`. Reads are combinational, from `rd_addr_i`. A seconds read is atomic: reading the low word also freezes the high word for the read that follows.

Top module: `pps_timebase`

## Requirements
- R1: The tick counter steps by one each cycle. In the cycle after the tick is at or above the active divisor (a wrap), the tick is 0.
- R2: `pps_o` is high for exactly the cycle after each wrap. In that cycle the tick is 0 and the seconds value has gone up by one.
- R3: `trig_o` goes high in the cycle after the tick equals the active trigger delay. It then stays high until the next wrap, so a second holds divisor minus delay high cycles.
- R4: `trig_o` is low in every PPS cycle. A delay at or above the active divisor never raises it. After reset the delay is all ones.
- R5: A write to address 4 (next divisor) becomes the active and the persistent divisor at the next wrap, and at no other time.
- R6: A write to address 5 (one-shot divisor) is active for the one second that starts at the next wrap. The wrap after that restores the persistent divisor.
- R7: A write to address 6 (trigger delay) becomes the active delay at the next wrap.
- R8: A write to address 0 sets the tick on the next cycle. A write to address 1 holds a low word. A write to address 2 then loads {data, held low word} into the seconds counter on the next cycle. Both immediate writes take priority over a wrap in the same cycle.
- R9: A write to address 3 stages {data, held low word}. The next wrap loads that value in place of the increment. Later wraps increment from it.
- R10: `pend_o` bits are [0] next divisor, [1] one-shot, [2] trigger delay, [3] seconds. Each bit is set by its write and cleared by the wrap that applies it. A second write before that wrap replaces the staged value.
- R11: A read of address 1 returns the live low seconds word and captures the high word. A later read of address 2 returns that captured word, even if a wrap came in between.
- R12: The read map is 0 tick, 1 seconds low, 2 captured seconds high, 3 persistent divisor, 4 active divisor, 6 active delay, others zero. After reset, tick, seconds, outputs and pending flags are zero and both divisors equal the default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe (captures seconds high on address 1) |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 32 | Read data, combinational |
| pps_o | output | 1 | One-cycle strobe at the start of each second |
| trig_o | output | 1 | Timed sampling trigger level |
| pend_o | output | 4 | Staged-update pending flags |

## Verification
The assertions check on every cycle the properties that need only one cycle of history:
- the tick either steps by one or returns to zero;
- the seconds counter stays put between wraps and increments, loads a staged value or loads an immediate write at the right edge;
- the trigger clears at each wrap and sets on a delay match;
- the divisor changes only at a wrap, and returns to the persistent value after a one-shot.

Only the bench's scenarios can show properties that span whole seconds:
- PPS spacing equals the divisor plus one, including the one-shot second followed by the restored period;
- the trigger's high-cycle count across a sweep of delays, including delays at and beyond the divisor;
- staged values that are overwritten before they apply;
- a seconds read whose two halves straddle a wrap.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [2:0] {
    A_TICK     = 3'd0,
    A_SEC_LO   = 3'd1,
    A_SEC_NOW  = 3'd2,
    A_SEC_NXT  = 3'd3,
    A_DIV_NXT  = 3'd4,
    A_DIV_ONE  = 3'd5,
    A_TRIG_NXT = 3'd6,
    A_RSVD     = 3'd7
  } reg_addr_e;

  typedef enum int unsigned {
    P_DIV  = 0,
    P_ONE  = 1,
    P_TRIG = 2,
    P_SEC  = 3
  } pend_bit_e;
endpackage

// File: rtl/pps_tick_ctr.sv
module pps_tick_ctr #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] DEF_DIV = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_we_i,
  input  logic         div_we_i,
  input  logic         one_we_i,
  input  logic [W-1:0] wd_i,
  output logic [W-1:0] tick_o,
  output logic         wrap_o,
  output logic         pps_o,
  output logic [W-1:0] act_div_o,
  output logic [W-1:0] base_div_o,
  output logic         div_pend_o,
  output logic         one_pend_o
);
  logic [W-1:0] tick_q, act_q, base_q, div_nxt_q, one_val_q, base_nxt;
  logic div_pend_q, one_pend_q, pps_q, wrap;

  assign wrap     = tick_q >= act_q;
  assign base_nxt = div_pend_q ? div_nxt_q : base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q     <= '0;
      act_q      <= DEF_DIV;
      base_q     <= DEF_DIV;
      div_nxt_q  <= DEF_DIV;
      one_val_q  <= '0;
      div_pend_q <= 1'b0;
      one_pend_q <= 1'b0;
      pps_q      <= 1'b0;
    end else begin
      tick_q     <= tick_we_i ? wd_i : (wrap ? '0 : tick_q + 1'b1);
      pps_q      <= wrap;
      if (div_we_i) div_nxt_q <= wd_i;
      if (one_we_i) one_val_q <= wd_i;
      // pending applied with pre-write value, so a write in the wrap cycle waits
      div_pend_q <= div_we_i | (div_pend_q & ~wrap);
      one_pend_q <= one_we_i | (one_pend_q & ~wrap);
      if (wrap) begin
        base_q <= base_nxt;
        act_q  <= one_pend_q ? one_val_q : base_nxt;
      end
    end
  end

  assign tick_o     = tick_q;
  assign wrap_o     = wrap;
  assign pps_o      = pps_q;
  assign act_div_o  = act_q;
  assign base_div_o = base_q;
  assign div_pend_o = div_pend_q;
  assign one_pend_o = one_pend_q;

  assert_tick_wraps_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && !tick_we_i) |=> tick_q == '0);
  assert_tick_steps_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wrap && !tick_we_i) |=> tick_q == $past(tick_q) + 1'b1);
  assert_div_only_at_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(act_q));
  assert_one_shot_reverts_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && !one_pend_q) |=> act_q == base_q);
  assert_pend_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && !div_we_i && !one_we_i) |=> !div_pend_q && !one_pend_q);
endmodule

// File: rtl/pps_sec_ctr.sv
module pps_sec_ctr #(
  parameter int unsigned W = 32,
  localparam int unsigned SW = 2 * W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wrap_i,
  input  logic          lo_we_i,
  input  logic          now_we_i,
  input  logic          nxt_we_i,
  input  logic [W-1:0]  wd_i,
  input  logic          snap_i,
  output logic [SW-1:0] sec_o,
  output logic [W-1:0]  snap_hi_o,
  output logic          pend_o
);
  logic [SW-1:0] sec_q, nxt_q;
  logic [W-1:0]  hold_q, snap_q;
  logic          pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= '0;
      nxt_q  <= '0;
      hold_q <= '0;
      snap_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (lo_we_i)  hold_q <= wd_i;
      if (nxt_we_i) nxt_q  <= {wd_i, hold_q};
      pend_q <= nxt_we_i | (pend_q & ~wrap_i);
      if (now_we_i)    sec_q <= {wd_i, hold_q};
      else if (wrap_i) sec_q <= pend_q ? nxt_q : sec_q + 1'b1;
      // capture high half together with the live low read
      if (snap_i) snap_q <= sec_q[SW-1:W];
    end
  end

  assign sec_o     = sec_q;
  assign snap_hi_o = snap_q;
  assign pend_o    = pend_q;

  assert_sec_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wrap_i && !now_we_i) |=> $stable(sec_q));
  assert_sec_incr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && !now_we_i && !pend_q) |=> sec_q == $past(sec_q) + 1'b1);
  assert_sec_now_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    now_we_i |=> sec_q[SW-1:W] == $past(wd_i));
  assert_sec_staged_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && pend_q && !now_we_i) |=> sec_q == $past(nxt_q));
endmodule

// File: rtl/pps_trigger.sv
module pps_trigger #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] DEF_DLY = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wrap_i,
  input  logic [W-1:0] tick_i,
  input  logic         we_i,
  input  logic [W-1:0] wd_i,
  output logic         trig_o,
  output logic [W-1:0] dly_o,
  output logic         pend_o
);
  logic [W-1:0] dly_q, nxt_q;
  logic         pend_q, trig_q, hit;

  assign hit = tick_i == dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q  <= DEF_DLY;
      nxt_q  <= DEF_DLY;
      pend_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      if (we_i) nxt_q <= wd_i;
      pend_q <= we_i | (pend_q & ~wrap_i);
      if (wrap_i) begin
        trig_q <= 1'b0;
        if (pend_q) dly_q <= nxt_q;
      end else if (hit) begin
        trig_q <= 1'b1;
      end
    end
  end

  assign trig_o = trig_q;
  assign dly_o  = dly_q;
  assign pend_o = pend_q;

  assert_trig_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> !trig_q);
  assert_trig_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !wrap_i) |=> trig_q);
  assert_trig_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q && !wrap_i) |=> trig_q);
  assert_dly_staged_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(dly_q));
endmodule

// File: rtl/pps_timebase.sv
module pps_timebase
  import pps_pkg::*;
#(
  parameter int unsigned DEFAULT_DIV = 200000000 - 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [2:0]  wr_addr_i,
  input  logic [31:0] wr_data_i,
  input  logic        rd_en_i,
  input  logic [2:0]  rd_addr_i,
  output logic [31:0] rd_data_o,
  output logic        pps_o,
  output logic        trig_o,
  output logic [3:0]  pend_o
);
  localparam int unsigned DW = 32;
  localparam int unsigned SW = 2 * DW;

  logic [DW-1:0] tick, act_div, base_div, dly, snap_hi;
  logic [SW-1:0] sec;
  logic wrap, div_pend, one_pend, sec_pend, trig_pend;

  function automatic logic we(input reg_addr_e a);
    return wr_en_i && (reg_addr_e'(wr_addr_i) == a);
  endfunction

  pps_tick_ctr #(.W(DW), .DEF_DIV(DW'(DEFAULT_DIV))) u_tick (
    .clk_i, .rst_ni,
    .tick_we_i (we(A_TICK)),
    .div_we_i  (we(A_DIV_NXT)),
    .one_we_i  (we(A_DIV_ONE)),
    .wd_i      (wr_data_i),
    .tick_o    (tick),
    .wrap_o    (wrap),
    .pps_o     (pps_o),
    .act_div_o (act_div),
    .base_div_o(base_div),
    .div_pend_o(div_pend),
    .one_pend_o(one_pend)
  );

  pps_sec_ctr #(.W(DW)) u_sec (
    .clk_i, .rst_ni,
    .wrap_i   (wrap),
    .lo_we_i  (we(A_SEC_LO)),
    .now_we_i (we(A_SEC_NOW)),
    .nxt_we_i (we(A_SEC_NXT)),
    .wd_i     (wr_data_i),
    .snap_i   (rd_en_i && (reg_addr_e'(rd_addr_i) == A_SEC_LO)),
    .sec_o    (sec),
    .snap_hi_o(snap_hi),
    .pend_o   (sec_pend)
  );

  pps_trigger #(.W(DW)) u_trig (
    .clk_i, .rst_ni,
    .wrap_i(wrap),
    .tick_i(tick),
    .we_i  (we(A_TRIG_NXT)),
    .wd_i  (wr_data_i),
    .trig_o(trig_o),
    .dly_o (dly),
    .pend_o(trig_pend)
  );

  always_comb begin
    pend_o         = '0;
    pend_o[P_DIV]  = div_pend;
    pend_o[P_ONE]  = one_pend;
    pend_o[P_TRIG] = trig_pend;
    pend_o[P_SEC]  = sec_pend;
  end

  always_comb begin
    unique case (reg_addr_e'(rd_addr_i))
      A_TICK:     rd_data_o = tick;
      A_SEC_LO:   rd_data_o = sec[DW-1:0];
      A_SEC_NOW:  rd_data_o = snap_hi;
      A_SEC_NXT:  rd_data_o = base_div;
      A_DIV_NXT:  rd_data_o = act_div;
      A_TRIG_NXT: rd_data_o = dly;
      default:    rd_data_o = '0;
    endcase
  end

  assert_pps_after_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pps_o |-> tick == '0 || $past(wr_en_i));
endmodule

// File: tb/pps_timebase_bench.sv
module pps_timebase_bench;
  localparam int unsigned DIV = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic pps, trig;
  logic [3:0] pend;
  int n_chk = 0, n_fail = 0;
  bit model_on = 1'b0;

  always #2.5 clk = ~clk;

  pps_timebase #(.DEFAULT_DIV(DIV)) u_pps_timebase (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .pps_o(pps), .trig_o(trig), .pend_o(pend)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model of the requirements, counters only
  logic [31:0] m_tick, m_div, m_base, m_dnxt, m_one, m_dly, m_tnxt;
  logic m_dp, m_op, m_tp, m_trig, m_pps, m_wrap;
  assign m_wrap = m_tick >= m_div;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tick <= 0; m_div <= DIV; m_base <= DIV; m_dnxt <= DIV; m_one <= 0;
      m_dly <= '1; m_tnxt <= '1; m_dp <= 0; m_op <= 0; m_tp <= 0;
      m_trig <= 0; m_pps <= 0;
    end else begin
      logic [31:0] nb;
      nb = m_dp ? m_dnxt : m_base;
      m_pps <= m_wrap;
      m_tick <= (wr_en && wr_addr == 0) ? wr_data : (m_wrap ? 0 : m_tick + 1);
      if (wr_en && wr_addr == 4) m_dnxt <= wr_data;
      if (wr_en && wr_addr == 5) m_one <= wr_data;
      if (wr_en && wr_addr == 6) m_tnxt <= wr_data;
      m_dp <= (wr_en && wr_addr == 4) || (m_dp && !m_wrap);
      m_op <= (wr_en && wr_addr == 5) || (m_op && !m_wrap);
      m_tp <= (wr_en && wr_addr == 6) || (m_tp && !m_wrap);
      if (m_wrap) begin
        m_base <= nb;
        m_div  <= m_op ? m_one : nb;
        m_trig <= 0;
        if (m_tp) m_dly <= m_tnxt;
      end else if (m_tick == m_dly) m_trig <= 1;
    end
  end

  always @(negedge clk) if (model_on) begin
    check("R1 tick", u_pps_timebase.rd_addr_i == 0 ? rd_data : m_tick, m_tick);
    check("R2 pps", pps, m_pps);
    check("R3/R4 trig", trig, m_trig);
    check("R10 pend", pend[2:0], {m_tp, m_op, m_dp});
  end

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    step();
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a; #0.5; d = rd_data; rd_addr = 0;
  endtask

  task automatic rd_sec(output logic [63:0] v);
    rd_addr = 1; rd_en = 1; #0.5; v[31:0] = rd_data;
    step();
    rd_en = 0; rd_addr = 2; #0.5; v[63:32] = rd_data; rd_addr = 0;
  endtask

  // returns at posedge+1 right after the edge that produced a PPS cycle
  task automatic wait_pps;
    do step(); while (!pps);
  endtask

  task automatic period(output int n);
    n = 0;
    do begin step(); n++; end while (!pps);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d32;
    logic [63:0] s;
    int p, hi_cnt;
    step(3);
    check("R12 reset pps", pps, 0);
    check("R12 reset trig", trig, 0);
    check("R12 reset pend", pend, 0);
    rd(0, d32); check("R12 reset tick", d32, 0);
    rd(3, d32); check("R12 reset base div", d32, DIV);
    rd(4, d32); check("R12 reset active div", d32, DIV);
    rd(6, d32); check("R4 reset delay", d32, 32'hFFFF_FFFF);
    rd_sec(s);  check("R12 reset seconds", s, 0);
    @(posedge clk); #1 rst_n = 1;
    step();
    model_on = 1;
    step(25);

    // R4: default delay never fires
    wait_pps; hi_cnt = 0;
    repeat (DIV + 1) begin if (trig) hi_cnt++; step(); end
    check("R4 default delay silent", hi_cnt, 0);

    // R3/R4/R7 delay sweep
    for (int d = 0; d <= DIV + 2; d++) begin
      wr(6, d);
      check("R10 trig pend set", pend[2], 1);
      wait_pps;
      check("R7 delay applied", pend[2], 0);
      rd(6, d32); check("R7 active delay", d32, d);
      hi_cnt = 0;
      repeat (DIV + 1) begin if (trig) hi_cnt++; step(); end
      check("R3 trig high cycles", hi_cnt, (d < DIV) ? DIV - d : 0);
    end

    // R5 next divisor
    wr(4, 4);
    rd(4, d32); check("R5 not yet active", d32, DIV);
    wait_pps; period(p); check("R5 new period", p, 5);
    rd(3, d32); check("R5 base divisor", d32, 4);
    // R6 one-shot
    wr(5, 2);
    wait_pps; period(p); check("R6 one-shot period", p, 3);
    rd(3, d32); check("R6 base kept", d32, 4);
    period(p); check("R6 restored period", p, 5);
    wr(4, DIV); wait_pps;

    // R8 immediate tick and seconds
    wr(0, 5);
    rd(0, d32); check("R8 tick write", d32, 5);
    wr(1, 5); wr(2, 1);
    rd_sec(s); check("R8 seconds write", s, 64'h1_0000_0005);

    // R9 staged seconds replaces increment
    wait_pps;
    wr(1, 32'hFFFF_FFFF); wr(3, 32'hFFFF_FFFF);
    check("R10 sec pend set", pend[3], 1);
    wait_pps;
    check("R10 sec pend cleared", pend[3], 0);
    rd_sec(s); check("R9 staged load", s, 64'hFFFF_FFFF_FFFF_FFFF);
    wait_pps; rd_sec(s); check("R9 increment after load", s, 0);

    // R10 overwrite before PPS
    wr(1, 100); wr(3, 0); wr(1, 200); wr(3, 0);
    wait_pps; rd_sec(s); check("R10 overwrite", s, 200);

    // R11 atomic read across a wrap
    wr(1, 32'hFFFF_FFFF); wr(2, 0);
    while (m_tick != DIV) step();
    rd_sec(s); check("R11 torn-free read", s, 64'h0_FFFF_FFFF);
    rd_sec(s); check("R11 after wrap", s, 64'h1_0000_0000);

    step(5);
    model_on = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule